// File: doc/BRIEF.md
# Ring-Driven Transmit DMA Engine

This block walks a circular table of transmit descriptors held in memory and turns each referenced buffer into a byte stream marked with frame start and frame end. Software fills descriptors, then moves a tail pointer register forward to hand them over. The engine fetches each descriptor as four 32-bit reads from a shared memory read port. It then reads the buffer one word at a time and sends the bytes out least significant first. A descriptor can ask for an interrupt when it completes, and it can mark the end of the table so that the engine returns to the ring base.

Shutdown takes two steps. The suspend control stops the engine at the next descriptor boundary, in a stopped state. Clearing the enable lets the descriptor in flight finish and then enters the disabled state. Status word 0 reports the engine state.

Top module: `txdma_ring`

## Requirements
- R1: After reset, every register reads zero, status word 0 reports disabled (code 0), `irq` is low and `out_valid` is low.
- R2: Register 4 (status 0) holds the engine state in bits 31:28: 0 disabled, 1 active, 2 idle, 3 stopped. Bits 15:0 hold the bytes still to send from the current buffer.
- R3: A descriptor at address A is fetched as reads of A, A+4, A+8 and A+12. A is the 64-bit address {high base (reg 2), low base (reg 1)} plus 16 times the ring index. Register 5 (status 1) reads A bits 31:0.
- R4: Descriptor word 1 bits 14:0 give the byte count. Word 2 and word 3 give buffer address bits 31:0 and 63:32. The buffer is 4-byte aligned. Bytes leave in address order, each word least significant byte first, and a partial last word is cut at the count.
- R5: Word 0 flag bits are: bit 31 start, bit 30 end, bit 29 interrupt on completion, bit 28 end of table. `out_sof` is high only on the first byte of a descriptor whose start flag is set. `out_eof` is high only on its last byte when the end flag is set.
- R6: The engine fetches only while bits 31:4 of the current descriptor address differ from bits 31:4 of the tail pointer (reg 3). When they are equal it sits idle.
- R7: After a descriptor with the end-of-table flag, the next descriptor address is the ring base.
- R8: When a descriptor with the interrupt flag completes, it sets interrupt status (reg 6 bit 0), which drives `irq`. Writing 1 to that bit clears it. Writing 0 has no effect.
- R9: Control bit 1 (suspend) lets the current descriptor finish and then holds the engine in the stopped state with no further fetches. Clearing the bit resumes work.
- R10: Clearing control bit 0 (enable) during a frame lets that descriptor finish, with the state still active, and then moves to disabled. Enabling again restarts at the ring base.
- R11: Control bit 11 (parity disable) and bits 20:18 (burst length) are stored and read back. All other control bits except 1:0 read as zero.
- R12: Once raised, `mem_rd` stays high with a stable `mem_addr` until `mem_rvalid`. Once raised, `out_valid` stays high with stable data until `out_ready`.
- R13: A descriptor with a byte count of zero sends no bytes but still completes, advances the ring and raises its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 ctrl, 1 base low, 2 base high, 3 tail, 4 status 0, 5 status 1, 6 interrupt) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory byte address |
| mem_rvalid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets the tail pointer comparison. A design that ignored it would run past posted work or would start while the ring is still empty. A chain that ends with an end-of-table descriptor checks that a missed wrap, which would fetch past the table, shows up in status 1 and the fetch log. Suspend and disable are both applied in the middle of a frame with the sink stalled. An engine that cut a frame short, or went on to the next descriptor, would send the wrong byte count. A zero-length descriptor and a nonzero high base check that the engine neither hangs on an empty buffer nor drops the upper address bits.

// File: rtl/txdma_ring.sv
module txdma_ring #(
  parameter int CNT_W = 15,
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_rd,
  output logic [63:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  input  logic        out_ready,
  output logic        irq
);
  localparam logic [3:0] C_OFF = 4'd0, C_RUN = 4'd1, C_IDLE = 4'd2, C_STOP = 4'd3;

  typedef enum logic [2:0] {S_OFF, S_IDLE, S_SUSP, S_FETCH, S_XFER, S_EMIT, S_DONE} st_t;
  st_t st;

  logic             en, susp, pdis, int_st;
  logic [2:0]       blen;
  logic [31:4]      base_lo;
  logic [31:0]      base_hi, tail;
  logic [IDX_W-1:0] idx;
  logic [1:0]       wcnt, bsel;
  logic             f_sof, f_eof, f_ioc, f_eot;
  logic [CNT_W-1:0] cnt, rem;
  logic [63:0]      baddr, cur_desc;
  logic [31:0]      wbuf;
  logic [3:0]       code;
  logic             pending, xfer_ok;

  assign cur_desc = {base_hi, base_lo, 4'b0} + 64'({idx, 4'b0});
  assign pending  = cur_desc[31:4] != tail[31:4];
  assign mem_rd   = (st == S_FETCH) || (st == S_XFER);
  assign mem_addr = (st == S_FETCH) ? cur_desc + 64'({wcnt, 2'b0}) : baddr;
  assign xfer_ok  = mem_rd && mem_rvalid;
  assign out_valid = (st == S_EMIT);
  assign out_data  = wbuf[8*bsel +: 8];
  assign out_sof   = out_valid && f_sof && (rem == cnt);
  assign out_eof   = out_valid && f_eof && (rem == CNT_W'(1));
  assign irq       = int_st;

  always_comb begin
    case (st)
      S_OFF:   code = C_OFF;
      S_IDLE:  code = C_IDLE;
      S_SUSP:  code = C_STOP;
      default: code = C_RUN;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {11'b0, blen, 6'b0, pdis, 9'b0, susp, en};
      3'd1:    reg_rdata = {base_lo, 4'b0};
      3'd2:    reg_rdata = base_hi;
      3'd3:    reg_rdata = tail;
      3'd4:    reg_rdata = {code, 12'b0, 16'(rem)};
      3'd5:    reg_rdata = cur_desc[31:0];
      3'd6:    reg_rdata = {31'b0, int_st};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; susp <= 1'b0; pdis <= 1'b0; blen <= '0;
      base_lo <= '0; base_hi <= '0; tail <= '0; int_st <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin
            en <= reg_wdata[0]; susp <= reg_wdata[1];
            pdis <= reg_wdata[11]; blen <= reg_wdata[20:18];
          end
          3'd1: base_lo <= reg_wdata[31:4];
          3'd2: base_hi <= reg_wdata;
          3'd3: tail    <= reg_wdata;
          default: ;
        endcase
      end
      if (st == S_DONE && f_ioc) int_st <= 1'b1;
      else if (reg_wr && reg_addr == 3'd6 && reg_wdata[0]) int_st <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OFF; idx <= '0; wcnt <= '0; bsel <= '0;
      {f_sof, f_eof, f_ioc, f_eot} <= '0;
      cnt <= '0; rem <= '0; baddr <= '0; wbuf <= '0;
    end else begin
      case (st)
        S_OFF: if (en) begin st <= S_IDLE; idx <= '0; end
        S_IDLE:
          if (!en)          st <= S_OFF;
          else if (susp)    st <= S_SUSP;
          else if (pending) begin st <= S_FETCH; wcnt <= '0; end
        S_SUSP:
          if (!en)        st <= S_OFF;
          else if (!susp) st <= S_IDLE;
        S_FETCH: if (xfer_ok) begin
          wcnt <= wcnt + 2'd1;
          case (wcnt)
            2'd0: {f_sof, f_eof, f_ioc, f_eot} <= mem_rdata[31:28];
            2'd1: cnt <= mem_rdata[CNT_W-1:0];
            2'd2: baddr[31:0] <= mem_rdata;
            default: begin
              baddr[63:32] <= mem_rdata;
              rem  <= cnt;
              bsel <= '0;
              st   <= (cnt == '0) ? S_DONE : S_XFER;
            end
          endcase
        end
        S_XFER: if (xfer_ok) begin wbuf <= mem_rdata; st <= S_EMIT; end
        S_EMIT: if (out_ready) begin
          rem  <= rem - CNT_W'(1);
          bsel <= bsel + 2'd1;
          if (rem == CNT_W'(1)) st <= S_DONE;
          else if (bsel == 2'd3) begin baddr <= baddr + 64'd4; st <= S_XFER; end
        end
        default: begin
          idx <= f_eot ? '0 : idx + IDX_W'(1);
          st  <= S_IDLE;
        end
      endcase
    end
  end

  // R12: memory request held until accepted
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));
  // R12: output byte held until accepted
  a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof)));
  // R8: interrupt only rises after a descriptor completes
  a_r8_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(st == S_DONE));
  // R2: bytes only leave while reported active
  a_r2_out_active: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (code == C_RUN));
  // R10: no memory traffic while disabled
  a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (code == C_OFF) |-> !mem_rd);
  // R9: stopped engine issues no reads
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (code == C_STOP) |-> (!mem_rd && !out_valid));
endmodule

// File: tb/sim_txdma_ring.sv
module sim_txdma_ring;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_rd, mem_rvalid;
  logic [63:0] mem_addr;
  logic [31:0] mem_rdata;
  logic out_valid, out_sof, out_eof, out_ready, irq;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:255];
  logic [7:0] cap_d [0:63];
  logic cap_s [0:63], cap_e [0:63];
  int nb = 0, nfetch = 0;
  logic [31:0] last_hi = 0;
  logic hold = 0, bp = 0;
  int pat = 0;

  always #10 clk = ~clk;

  txdma_ring u0 (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_rd, .mem_addr, .mem_rvalid, .mem_rdata,
    .out_valid, .out_data, .out_sof, .out_eof, .out_ready, .irq);

  assign out_ready = !hold && (!bp || (pat % 3 != 0));
  always @(negedge clk) pat <= pat + 1;

  always @(posedge clk) begin
    if (!rst_n) mem_rvalid <= 1'b0;
    else begin
      mem_rvalid <= mem_rd && !mem_rvalid;
      mem_rdata  <= mem[mem_addr[9:2]];
      if (mem_rd && !mem_rvalid && mem_addr[9:0] < 10'h200) begin
        nfetch  <= nfetch + 1;
        last_hi <= mem_addr[63:32];
      end
    end
    if (out_valid && out_ready) begin
      cap_d[nb % 64] <= out_data; cap_s[nb % 64] <= out_sof; cap_e[nb % 64] <= out_eof;
      nb <= nb + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_code(input logic [3:0] c);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd4, v);
      if (v[31:28] == c) return;
    end
    chk(0, "R2", "state wait timeout", v[31:28], c);
  endtask

  task automatic wait_outv();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (out_valid) return;
    end
    chk(0, "R12", "out_valid wait timeout", 0, 1);
  endtask

  task automatic check_frame(input string req, input int start, input int n,
                             input logic [7:0] exp [], input bit sof0, input bit eofn);
    chk(nb - start == n, req, "byte count", nb - start, n);
    for (int i = 0; i < n; i++) begin
      chk(cap_d[(start+i)%64] == exp[i], req, $sformatf("byte %0d", i), cap_d[(start+i)%64], exp[i]);
      chk(cap_s[(start+i)%64] == (sof0 && i == 0), "R5", $sformatf("sof %0d", i), cap_s[(start+i)%64], sof0 && i == 0);
      chk(cap_e[(start+i)%64] == (eofn && i == n-1), "R5", $sformatf("eof %0d", i), cap_e[(start+i)%64], eofn && i == n-1);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1", $sformatf("reg %0d after reset", a), v, 0);
    end
    chk(!irq && !out_valid, "R1", "irq/out_valid after reset", {irq, out_valid}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFC);
    rd(3'd0, v);
    chk(v == 32'h001C_0800, "R11", "ctrl readback", v, 32'h001C_0800);
    wr(3'd0, 0);
  endtask

  task automatic t_first();
    logic [31:0] v;
    int s, f;
    wr(3'd1, 32'h100); wr(3'd3, 32'h100); wr(3'd0, 1);
    repeat (10) @(negedge clk);
    rd(3'd4, v);
    chk(v[31:28] == 2, "R6", "idle with tail at base", v[31:28], 2);
    chk(nfetch == 0, "R6", "no fetch when empty", nfetch, 0);
    s = nb; f = nfetch;
    wr(3'd3, 32'h110);
    for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
    wait_code(4'd2);
    check_frame("R4", s, 6, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, 1, 1);
    chk(nfetch - f == 4, "R3", "four descriptor reads", nfetch - f, 4);
    chk(irq, "R8", "irq after ioc", irq, 1);
    rd(3'd5, v);
    chk(v == 32'h110, "R3", "status1 after one", v, 32'h110);
    wr(3'd6, 0);
    chk(irq, "R8", "write 0 keeps irq", irq, 1);
    wr(3'd6, 1);
    chk(!irq, "R8", "write 1 clears irq", irq, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int s;
    s = nb; bp = 1;
    wr(3'd3, 32'h100);
    for (int i = 0; i < 1000 && !irq; i++) @(negedge clk);
    wait_code(4'd2);
    bp = 0;
    check_frame("R7", s, 12, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
                               8'h09, 8'hAA, 8'hBB, 8'hCC}, 1, 1);
    rd(3'd5, v);
    chk(v == 32'h100, "R7", "wrap to base", v, 32'h100);
    chk(irq, "R8", "irq from last", irq, 1);
    wr(3'd6, 1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int s;
    mem[64] = 32'h2000_0000; mem[65] = 0;
    s = nb;
    wr(3'd3, 32'h110);
    for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
    wait_code(4'd2);
    chk(nb == s, "R13", "no bytes for zero count", nb - s, 0);
    chk(irq, "R13", "irq for zero count", irq, 1);
    rd(3'd5, v);
    chk(v == 32'h110, "R13", "ring advanced", v, 32'h110);
    wr(3'd6, 1);
  endtask

  task automatic t_suspend();
    logic [31:0] v;
    int s, f;
    wr(3'd0, 3);
    wait_code(4'd3);
    s = nb; f = nfetch;
    wr(3'd3, 32'h120);
    repeat (40) @(negedge clk);
    rd(3'd4, v);
    chk(v[31:28] == 3, "R9", "stays stopped", v[31:28], 3);
    chk(nb == s && nfetch == f, "R9", "no activity while stopped", nfetch - f, 0);
    wr(3'd0, 1);
    repeat (5) @(negedge clk);
    wait_code(4'd2);
    check_frame("R9", s, 9, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}, 1, 0);
    s = nb; hold = 1;
    wr(3'd3, 32'h110);
    wait_outv();
    wr(3'd0, 3);
    hold = 0;
    wait_code(4'd3);
    check_frame("R9", s, 3, '{8'hAA, 8'hBB, 8'hCC}, 0, 1);
    rd(3'd5, v);
    chk(v == 32'h100, "R9", "stopped after current", v, 32'h100);
    wr(3'd6, 1);
    wr(3'd0, 1);
    for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
    wait_code(4'd2);
    rd(3'd5, v);
    chk(v == 32'h110, "R9", "resumed", v, 32'h110);
    wr(3'd6, 1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    int s, f;
    s = nb; hold = 1;
    wr(3'd3, 32'h120);
    wait_outv();
    wr(3'd0, 0);
    rd(3'd4, v);
    chk(v[31:28] == 1, "R10", "active until done", v[31:28], 1);
    hold = 0;
    wait_code(4'd0);
    check_frame("R10", s, 9, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}, 1, 0);
    mem[64] = 32'hE000_0000; mem[65] = 6;
    wr(3'd2, 32'h5); wr(3'd3, 32'h100); wr(3'd0, 1);
    wait_code(4'd2);
    rd(3'd5, v);
    chk(v == 32'h100, "R10", "restart at base", v, 32'h100);
    s = nb; f = nfetch;
    wr(3'd3, 32'h110);
    for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
    wait_code(4'd2);
    chk(nfetch - f == 4 && last_hi == 5, "R3", "high base on fetch", last_hi, 5);
    check_frame("R4", s, 6, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, 1, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    mem[64] = 32'hE000_0000; mem[65] = 6; mem[66] = 32'h200; mem[67] = 0;
    mem[128] = 32'h4433_2211; mem[129] = 32'h0000_6655;
    mem[68] = 32'h8000_0000; mem[69] = 9; mem[70] = 32'h210; mem[71] = 0;
    mem[132] = 32'h0403_0201; mem[133] = 32'h0807_0605; mem[134] = 32'h0000_0009;
    mem[72] = 32'h7000_0000; mem[73] = 3; mem[74] = 32'h220; mem[75] = 0;
    mem[136] = 32'h00CC_BBAA;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_first();
    t_wrap();
    t_zero();
    t_suspend();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule